// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block turns an indexed-addressing postbyte, together with up to two extension bytes, into a 16-bit effective address. The postbyte chooses a base register (X, Y, SP or PC) and one of several offset sources. The offset can be a small signed constant held inside the postbyte, a 9-bit or 16-bit signed constant taken from the extension bytes, or an unsigned accumulator value (A, B or the concatenated D). The postbyte can also select an automatic increment or decrement of the base register, applied either before or after the address is formed. Two indirect forms use the computed sum as a pointer and fetch the final address from memory.

The sequencer presents the postbyte, the extension bytes and the current register values, then raises `start_i`. The block reports how many extension bytes the postbyte consumes. Direct forms complete in the cycle they are accepted. Indirect forms issue a 16-bit read over a request/valid handshake and complete when the data returns. Auto-modify forms also drive a one-cycle write-back strobe carrying the adjusted register value.

Top module: `idx_ea_gen`

## Requirements
- R1: With postbyte bit 7..5 not 111 and bit 5 = 0, base = register[bits 7:6] (00 X, 01 Y, 10 SP, 11 PC) and the offset is bits 4:0 sign-extended (-16..+15). No extension bytes are used.
- R2: Postbyte 111rr00s adds the 9-bit signed offset {s, ext0} to register rr. It uses one extension byte.
- R3: Postbyte 111rr010 adds the 16-bit offset {ext0, ext1} (ext0 is the high byte) to register rr, with wrap-around modulo 2^16. It uses two extension bytes.
- R4: Postbyte 111rr011 forms the pointer rr + {ext0, ext1}. The effective address is the 16-bit word read from that pointer.
- R5: Postbyte rr1pnnnn (rr not 11) is auto-modify. nnnn 0000..0111 means +1..+8 and 1000..1111 means -8..-1. With p = 0 (pre) the effective address is the adjusted value; with p = 1 (post) it is the original register value.
- R6: In auto-modify, `wb_en_o` is high only in the accepting cycle, with `wb_sel_o` = rr and `wb_val_o` = the adjusted value. No other form raises `wb_en_o`, and PC is never a write-back target, because 11 1 xxxxx always decodes as a 111-prefixed form.
- R7: Postbyte 111rr1aa with aa = 00, 01 or 10 adds A, B (each zero-extended) or D = {A, B} to register rr, unsigned and modulo 2^16.
- R8: Postbyte 111rr111 forms the pointer rr + D. The effective address is the word read from that pointer.
- R9: `ext_cnt_o` follows the postbyte combinationally. It is 0 for the 5-bit, auto and accumulator forms, 1 for the 9-bit form, and 2 for both 16-bit constant forms.
- R10: A PC base uses `pc_i` exactly as presented. The caller supplies the address past the final extension byte.
- R11: A direct form raises `done_o` with `ea_o` in the same cycle that `start_i` is accepted. An indirect form instead holds `rd_req_o` high with a stable `rd_addr_o` from the next cycle until `rd_valid_i`. `done_o` is raised in that cycle with `ea_o` = `rd_data_i`, and the request drops on the following cycle.
- R12: `start_i` is ignored while an indirect read is outstanding: no `done_o` and no write-back result from it.
- R13: After reset, `rd_req_o`, `done_o` and `wb_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Inputs valid; accepted when no read is outstanding |
| postbyte_i | input | 8 | Indexed-mode postbyte |
| ext0_i | input | 8 | First extension byte |
| ext1_i | input | 8 | Second extension byte |
| x_i | input | 16 | X register value |
| y_i | input | 16 | Y register value |
| sp_i | input | 16 | Stack pointer value |
| pc_i | input | 16 | PC past the final extension byte |
| acc_a_i | input | 8 | Accumulator A |
| acc_b_i | input | 8 | Accumulator B |
| ext_cnt_o | output | 2 | Extension bytes required by postbyte |
| done_o | output | 1 | Effective address valid |
| ea_o | output | 16 | Effective address |
| wb_en_o | output | 1 | Index register write-back strobe |
| wb_sel_o | output | 2 | Write-back register (00 X, 01 Y, 10 SP) |
| wb_val_o | output | 16 | Adjusted register value |
| rd_req_o | output | 1 | Indirect pointer read request |
| rd_addr_o | output | 16 | Pointer address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 16 | Read data word |

## Verification
The bench targets the sign boundaries of each offset encoding: -16 and +15 in the 5-bit form, a negative 9-bit offset whose sign lives only in the postbyte, and the +8/-8/-1 ends of the auto-modify code. A decoder that forgets the +1 skew would step by 7 instead of 8, and one that sign-extends accumulator A would subtract instead of add 0x80. Pre- versus post-modify is checked on both the effective address and the write-back value, so swapping them shows up as an off-by-delta address. The indirect forms are held waiting for several cycles with a competing `start_i` pulse. This catches a request address that drifts, a stray `done_o`, or a second command accepted mid-read. A D-plus-PC sum that overflows 16 bits confirms wrap-around.

// File: rtl/idx_pkg.sv
package idx_pkg;
  localparam int AW = 16;
  localparam int BW = 8;

  typedef enum logic [1:0] {
    REG_X  = 2'b00,
    REG_Y  = 2'b01,
    REG_SP = 2'b10,
    REG_PC = 2'b11
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e        rsel;
    logic [AW-1:0]   offs;
    logic            is_auto;
    logic            is_post;
    logic            is_ind;
    logic [1:0]      ext_cnt;
  } idx_dec_t;
endpackage

// File: rtl/idx_decode.sv
module idx_decode
  import idx_pkg::*;
(
  input  logic [BW-1:0] pb_i,
  input  logic [BW-1:0] e0_i,
  input  logic [BW-1:0] e1_i,
  input  logic [BW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output idx_dec_t      dec_o
);
  localparam int K5W = 5;
  localparam int AMW = 4;

  always_comb begin
    dec_o = '0;
    if (pb_i[7:5] == 3'b111) begin
      dec_o.rsel = reg_sel_e'(pb_i[4:3]);
      if (!pb_i[2]) begin
        if (!pb_i[1]) begin
          dec_o.offs    = {{(AW-BW){pb_i[0]}}, e0_i};
          dec_o.ext_cnt = 2'd1;
        end else begin
          dec_o.offs    = {e0_i, e1_i};
          dec_o.ext_cnt = 2'd2;
          dec_o.is_ind  = pb_i[0];
        end
      end else begin
        unique case (pb_i[1:0])
          2'b00:   dec_o.offs = {{(AW-BW){1'b0}}, a_i};
          2'b01:   dec_o.offs = {{(AW-BW){1'b0}}, b_i};
          default: dec_o.offs = {a_i, b_i};
        endcase
        dec_o.is_ind = &pb_i[1:0];
      end
    end else begin
      dec_o.rsel = reg_sel_e'(pb_i[7:6]);
      if (!pb_i[5]) begin
        dec_o.offs = {{(AW-K5W){pb_i[K5W-1]}}, pb_i[K5W-1:0]};
      end else begin
        dec_o.is_auto = 1'b1;
        dec_o.is_post = pb_i[4];
        // non-negative codes are skewed by one so zero is never a step
        if (pb_i[AMW-1]) dec_o.offs = {{(AW-AMW){1'b1}}, pb_i[AMW-1:0]};
        else             dec_o.offs = {{(AW-AMW){1'b0}}, pb_i[AMW-1:0]} + AW'(1);
      end
    end
  end
endmodule

// File: rtl/idx_addr.sv
module idx_addr
  import idx_pkg::*;
(
  input  idx_dec_t      dec_i,
  input  logic [AW-1:0] x_i,
  input  logic [AW-1:0] y_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] sum_o,
  output logic [AW-1:0] ea_o
);
  localparam int NREG = 4;

  logic [AW-1:0] regs [NREG];
  logic [AW-1:0] base;

  assign regs[0] = x_i;
  assign regs[1] = y_i;
  assign regs[2] = sp_i;
  assign regs[3] = pc_i;

  assign base  = regs[dec_i.rsel];
  assign sum_o = base + dec_i.offs;
  assign ea_o  = (dec_i.is_auto && dec_i.is_post) ? base : sum_o;
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
  import idx_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [BW-1:0] postbyte_i,
  input  logic [BW-1:0] ext0_i,
  input  logic [BW-1:0] ext1_i,
  input  logic [AW-1:0] x_i,
  input  logic [AW-1:0] y_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] pc_i,
  input  logic [BW-1:0] acc_a_i,
  input  logic [BW-1:0] acc_b_i,
  output logic [1:0]    ext_cnt_o,
  output logic          done_o,
  output logic [AW-1:0] ea_o,
  output logic          wb_en_o,
  output logic [1:0]    wb_sel_o,
  output logic [AW-1:0] wb_val_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [AW-1:0] rd_data_i
);
  idx_dec_t      dec;
  logic [AW-1:0] sum, dir_ea, ptr_q;
  logic          wait_q, accept;

  idx_decode u_dec (
    .pb_i (postbyte_i), .e0_i (ext0_i), .e1_i (ext1_i),
    .a_i  (acc_a_i),    .b_i  (acc_b_i), .dec_o (dec)
  );

  idx_addr u_addr (
    .dec_i (dec), .x_i (x_i), .y_i (y_i), .sp_i (sp_i), .pc_i (pc_i),
    .sum_o (sum), .ea_o (dir_ea)
  );

  assign accept = start_i && !wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b0;
      ptr_q  <= '0;
    end else if (accept && dec.is_ind) begin
      wait_q <= 1'b1;
      ptr_q  <= sum;
    end else if (wait_q && rd_valid_i) begin
      wait_q <= 1'b0;
    end
  end

  assign ext_cnt_o = dec.ext_cnt;
  assign done_o    = (accept && !dec.is_ind) || (wait_q && rd_valid_i);
  assign ea_o      = wait_q ? rd_data_i : dir_ea;
  assign wb_en_o   = accept && dec.is_auto;
  assign wb_sel_o  = dec.rsel;
  assign wb_val_o  = sum;
  assign rd_req_o  = wait_q;
  assign rd_addr_o = ptr_q;

  a_r11_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));
  a_r11_req_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !rd_req_o);
  a_r6_wb_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> done_o && !rd_req_o);
  a_r6_wb_never_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> wb_sel_o != REG_PC);
  a_r9_ext_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_cnt_o != 2'd3);
  a_r12_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |-> !done_o && !wb_en_o);
endmodule

// File: tb/sim_idx_ea_gen.sv
`timescale 1ns/1ps
module sim_idx_ea_gen;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [7:0]  pb = 0, e0 = 0, e1 = 0, acc_a, acc_b;
  logic [15:0] xr, yr, spr, pcr;
  logic [1:0]  ext_cnt, wb_sel;
  logic        done, wb_en, rd_req, rd_valid = 0;
  logic [15:0] ea, wb_val, rd_addr, rd_data = 0;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  idx_ea_gen u0 (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .postbyte_i (pb),
    .ext0_i (e0), .ext1_i (e1), .x_i (xr), .y_i (yr), .sp_i (spr), .pc_i (pcr),
    .acc_a_i (acc_a), .acc_b_i (acc_b), .ext_cnt_o (ext_cnt), .done_o (done),
    .ea_o (ea), .wb_en_o (wb_en), .wb_sel_o (wb_sel), .wb_val_o (wb_val),
    .rd_req_o (rd_req), .rd_addr_o (rd_addr), .rd_valid_i (rd_valid),
    .rd_data_i (rd_data)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // direct form: drive, check same-cycle result, then clock and release
  task automatic direct(string req, logic [7:0] p, logic [7:0] x0, logic [7:0] x1,
                        logic [15:0] exp_ea, logic [1:0] exp_cnt,
                        logic exp_wb, logic [15:0] exp_wbv);
    @(negedge clk);
    pb = p; e0 = x0; e1 = x1; start = 1;
    #1;
    chk({req, " done"}, 16'(done), 16'd1);
    chk({req, " ea"}, ea, exp_ea);
    chk({req, " R9 ext_cnt"}, 16'(ext_cnt), 16'(exp_cnt));
    chk({req, " R6 wb_en"}, 16'(wb_en), 16'(exp_wb));
    if (exp_wb) begin
      chk({req, " R6 wb_sel"}, 16'(wb_sel), 16'(p[7:6]));
      chk({req, " R6 wb_val"}, wb_val, exp_wbv);
    end
    @(negedge clk);
    start = 0;
    #1;
    chk({req, " R6 strobe one cycle"}, 16'(wb_en), 16'd0);
    chk({req, " R11 no req"}, 16'(rd_req), 16'd0);
  endtask

  task automatic indirect(string req, logic [7:0] p, logic [7:0] x0, logic [7:0] x1,
                          logic [15:0] exp_ptr, logic [15:0] data, int waits,
                          logic [1:0] exp_cnt);
    @(negedge clk);
    pb = p; e0 = x0; e1 = x1; start = 1;
    #1;
    chk({req, " R11 no done at accept"}, 16'(done), 16'd0);
    chk({req, " R9 ext_cnt"}, 16'(ext_cnt), 16'(exp_cnt));
    @(negedge clk);
    // competing direct command while waiting (R12)
    pb = 8'h0F; start = 1;
    for (int i = 0; i < waits; i++) begin
      #1;
      chk({req, " R11 req"}, 16'(rd_req), 16'd1);
      chk({req, " R11 addr"}, rd_addr, exp_ptr);
      chk({req, " R12 no done"}, 16'(done), 16'd0);
      @(negedge clk);
    end
    start = 0;
    rd_valid = 1; rd_data = data;
    #1;
    chk({req, " R11 done on valid"}, 16'(done), 16'd1);
    chk({req, " ea from memory"}, ea, data);
    @(negedge clk);
    rd_valid = 0;
    #1;
    chk({req, " R11 req drops"}, 16'(rd_req), 16'd0);
    chk({req, " R12 no late done"}, 16'(done), 16'd0);
  endtask

  task automatic t_reset();
    #1;
    chk("R13 rd_req", 16'(rd_req), 16'd0);
    chk("R13 done", 16'(done), 16'd0);
    chk("R13 wb_en", 16'(wb_en), 16'd0);
  endtask

  task automatic t_k5();
    direct("R1 X+15", 8'h0F, 8'h00, 8'h00, 16'h100F, 2'd0, 0, 0);
    direct("R1 Y-16", 8'h50, 8'h00, 8'h00, 16'h1FF0, 2'd0, 0, 0);
    direct("R1 R10 PC+1", 8'hC1, 8'h00, 8'h00, 16'h8005, 2'd0, 0, 0);
  endtask

  task automatic t_k9();
    direct("R2 Y-240", 8'hE9, 8'h10, 8'h00, 16'h1F10, 2'd1, 0, 0);
    direct("R2 X+255", 8'hE0, 8'hFF, 8'h00, 16'h10FF, 2'd1, 0, 0);
  endtask

  task automatic t_k16();
    direct("R3 SP+1234", 8'hF2, 8'h12, 8'h34, 16'h5224, 2'd2, 0, 0);
    direct("R3 R10 PC wrap", 8'hFA, 8'h80, 8'h00, 16'h0004, 2'd2, 0, 0);
  endtask

  task automatic t_auto();
    direct("R5 pre +3 X", 8'h22, 8'h00, 8'h00, 16'h1003, 2'd0, 1, 16'h1003);
    direct("R5 post -1 SP", 8'hBF, 8'h00, 8'h00, 16'h3FF0, 2'd0, 1, 16'h3FEF);
    direct("R5 pre -8 Y", 8'h68, 8'h00, 8'h00, 16'h1FF8, 2'd0, 1, 16'h1FF8);
    direct("R5 post +8 X", 8'h37, 8'h00, 8'h00, 16'h1000, 2'd0, 1, 16'h1008);
  endtask

  task automatic t_acc();
    direct("R7 A,X unsigned", 8'hE4, 8'h00, 8'h00, 16'h1080, 2'd0, 0, 0);
    direct("R7 B,Y unsigned", 8'hED, 8'h00, 8'h00, 16'h20F3, 2'd0, 0, 0);
    direct("R7 R10 D,PC wrap", 8'hFE, 8'h00, 8'h00, 16'h00F7, 2'd0, 0, 0);
  endtask

  task automatic t_ind();
    indirect("R4 [n,X]", 8'hE3, 8'h00, 8'h20, 16'h1020, 16'hBEEF, 3, 2'd2);
    indirect("R8 [D,SP]", 8'hF7, 8'h00, 8'h00, 16'hC0E3, 16'h4321, 1, 2'd0);
  endtask

  initial begin
    xr = 16'h1000; yr = 16'h2000; spr = 16'h3FF0; pcr = 16'h8004;
    acc_a = 8'h80; acc_b = 8'hF3;
    t_reset();
    #9 rst_n = 1;
    t_k5();
    t_k9();
    t_k16();
    t_auto();
    t_acc();
    t_ind();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule